// File: doc/BRIEF.md
# Eight-bit waveform timer with forced compare

The block is an up-counting timer that drives one waveform pin. Software reaches it through a small register port: a control byte, the live count, a compare value and a flag register. The count steps only on cycles where the external prescaler raises `tick_i` and the clock-select field is non-zero. Two mode bits pick one of four counting patterns: free-running, clear at the compare value, single-slope PWM, or up/down PWM. In each pattern a compare match acts on the pin as the two-bit pin-action field selects.

Software can also force a compare action on the pin by writing a control byte with bit 7 set. The force applies the pin-action field carried by that same write at once. It sets no flag, raises no interrupt and leaves the count alone. It works only when the written mode is free-running or clear-at-compare. Bit 7 is never stored.

Register map (2-bit address): 0 control, 1 count, 2 compare, 3 flags. Control byte layout: bit 7 force strobe, bit 6 low mode bit, bits 5:4 pin action, bit 3 high mode bit, bits 2:0 clock select. The mode is {bit 3, bit 6}.

Top module: `tmr8_wavegen`

## Requirements
- R1: After reset the four registers read 0, and `wave_o`, `wave_oe_o`, `cmp_flag_o`, `ovf_flag_o` and `irq_o` are 0.
- R2: Read data appears on `rd_data_o` one cycle after `rd_en_i`. Control bit 7 always reads 0. Control bits 6:0 read back as last written. The flag register holds the compare flag in bit 0 and the overflow flag in bit 1.
- R3: With clock select 000 the count holds even when `tick_i` is high. With any other clock select it advances exactly once for each cycle that has `tick_i` high, and holds otherwise.
- R4: Mode 00 (free-running) counts up and wraps from 255 to 0. The edge that wraps it sets the overflow flag.
- R5: Mode 10 (clear at compare): a count enable that finds count equal to compare loads 0 on that edge and sets the compare flag. In every mode, an enable that finds count equal to compare sets the compare flag.
- R6: In modes 00 and 10 a match acts on the pin by pin action: 01 toggles, 10 clears, 11 sets, 00 leaves it unchanged. `wave_oe_o` is 1 exactly when the stored pin action is non-zero.
- R7: A control write with bit 7 set and a written mode of 00 or 10 applies the written pin action to `wave_o` on the same edge. It leaves the count and both flags unchanged, even when count equals compare in mode 10.
- R8: A control write with bit 7 set and a written mode of 01 or 11 leaves `wave_o` unchanged.
- R9: Mode 11 (single-slope PWM) counts 0 to 255 and wraps, setting the overflow flag at the wrap. Pin action 10 clears the pin on match and sets it at the wrap, and 11 does the reverse. A match on the wrap edge wins.
- R10: Mode 01 (up/down PWM) counts 0 up to 255, then down to 0, then up again. Pin action 10 clears the pin on a match while rising and sets it on a match while falling, and 11 does the reverse. The overflow flag is set on the edge that turns the count around at 0.
- R11: Writing 1 to a flag-register bit clears that flag, and a 0 leaves it. A hardware set in the same cycle wins over the clear. `irq_o` is 1 exactly when either flag is 1.
- R12: A count write takes effect on its edge and overrides a count enable in the same cycle. That enable then produces no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wr_data_i | input | CNT_W | Write data |
| rd_data_o | output | CNT_W | Registered read data |
| tick_i | input | 1 | Prescaled count enable |
| wave_o | output | 1 | Waveform pin level |
| wave_oe_o | output | 1 | Pin driven when 1 |
| cmp_flag_o | output | 1 | Compare flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request, OR of the flags |

## Verification
A wrong count or a lost direction bit first shows at the count register. It then spreads to the pin edge and the flags on the next enable that passes the compare value or a turning point. For that reason the bench reads the count back after a known number of enables and compares pin and flags against the same number. A stray force, or a force that leaks into the counter, shows on `wave_o` or the flags one edge after the control write. A flag that fails to stick, or an interrupt that drifts from the flags, shows within one cycle.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int ADDR_W = 2;
  localparam int CTRL_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMP   = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS = 2'd3;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PHASE  = 2'b01,
    MODE_CTC    = 2'b10,
    MODE_FAST   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic [1:0] pin_mode;
    tmr_mode_e  mode;
    logic [2:0] clk_sel;
  } ctrl_t;

  // bits 6:0 of the control byte; bit 7 is the strobe and is never stored
  function automatic ctrl_t ctrl_from_byte(input logic [CTRL_W-2:0] b);
    ctrl_t c;
    c.pin_mode = b[5:4];
    c.mode     = tmr_mode_e'({b[3], b[6]});
    c.clk_sel  = b[2:0];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_to_byte(input ctrl_t c);
    logic [1:0] m;
    m = c.mode;
    return {1'b0, m[0], c.pin_mode, m[1], c.clk_sel};
  endfunction

  function automatic logic is_pwm(input tmr_mode_e m);
    return (m == MODE_PHASE) || (m == MODE_FAST);
  endfunction

endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              match_i,
  input  logic              bottom_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              cmp_flag_o,
  output logic              ovf_flag_o,
  output logic              irq_o,
  output logic              cnt_wr_o,
  output logic              force_o,
  output logic [1:0]        force_act_o
);

  ctrl_t            ctrl_q;
  ctrl_t            ctrl_wr;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] rd_mux;
  logic             cmp_flag_q, ovf_flag_q, irq_q;
  logic             cmp_flag_nx, ovf_flag_nx;
  logic             sel_ctrl, sel_cmp, sel_flags;
  logic [1:0]       clr;

  assign sel_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign sel_cmp   = wr_en_i && (addr_i == A_CMP);
  assign sel_flags = wr_en_i && (addr_i == A_FLAGS);
  assign cnt_wr_o  = wr_en_i && (addr_i == A_COUNT);

  assign ctrl_wr     = ctrl_from_byte(wr_data_i[CTRL_W-2:0]);
  assign force_o     = sel_ctrl && wr_data_i[CTRL_W-1] && !is_pwm(ctrl_wr.mode);
  assign force_act_o = ctrl_wr.pin_mode;

  assign clr         = sel_flags ? wr_data_i[1:0] : 2'b00;
  assign cmp_flag_nx = match_i  | (cmp_flag_q & ~clr[0]);
  assign ovf_flag_nx = bottom_i | (ovf_flag_q & ~clr[1]);

  always_comb begin
    case (addr_i)
      A_CTRL:  rd_mux = CNT_W'(ctrl_to_byte(ctrl_q));
      A_COUNT: rd_mux = cnt_i;
      A_CMP:   rd_mux = cmp_q;
      default: rd_mux = CNT_W'({ovf_flag_q, cmp_flag_q});
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q     <= '0;
      cmp_q      <= '0;
      rd_q       <= '0;
      cmp_flag_q <= 1'b0;
      ovf_flag_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (sel_ctrl) ctrl_q <= ctrl_wr;
      if (sel_cmp)  cmp_q  <= wr_data_i;
      if (rd_en_i)  rd_q   <= rd_mux;
      cmp_flag_q <= cmp_flag_nx;
      ovf_flag_q <= ovf_flag_nx;
      irq_q      <= cmp_flag_nx | ovf_flag_nx;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cmp_o      = cmp_q;
  assign rd_data_o  = rd_q;
  assign cmp_flag_o = cmp_flag_q;
  assign ovf_flag_o = ovf_flag_q;
  assign irq_o      = irq_q;

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  tmr_mode_e        mode_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic             match_o,
  output logic             bottom_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             down_q, down_nx;
  logic             step, at_top, at_max, at_min, bottom;

  assign step   = run_i && !load_i;
  assign at_top = (cnt_q == cmp_i);
  assign at_max = (cnt_q == CNT_MAX);
  assign at_min = (cnt_q == CNT_MIN);

  always_comb begin
    cnt_nx  = cnt_q;
    down_nx = (mode_i == MODE_PHASE) ? down_q : 1'b0;
    bottom  = 1'b0;
    if (step) begin
      case (mode_i)
        MODE_CTC: begin
          if (at_top) begin
            cnt_nx = CNT_MIN;
          end else begin
            cnt_nx = cnt_q + ONE;
            bottom = at_max;
          end
        end
        MODE_PHASE: begin
          if (!down_q) begin
            if (at_max) begin
              down_nx = 1'b1;
              cnt_nx  = cnt_q - ONE;
            end else begin
              cnt_nx = cnt_q + ONE;
            end
          end else begin
            if (at_min) begin
              down_nx = 1'b0;
              cnt_nx  = ONE;
              bottom  = 1'b1;
            end else begin
              cnt_nx = cnt_q - ONE;
            end
          end
        end
        default: begin
          cnt_nx = cnt_q + ONE;
          bottom = at_max;
        end
      endcase
    end
    if (load_i) cnt_nx = load_val_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      down_q <= down_nx;
    end
  end

  assign cnt_o    = cnt_q;
  assign down_o   = down_q;
  assign match_o  = step && at_top;
  assign bottom_o = bottom;

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  tmr_mode_e  mode_i,
  input  logic [1:0] pin_mode_i,
  input  logic       match_i,
  input  logic       bottom_i,
  input  logic       down_i,
  input  logic       force_i,
  input  logic [1:0] force_act_i,
  output logic       wave_o
);

  logic wave_q, wave_nx;

  function automatic logic pin_apply(input logic cur, input logic [1:0] act);
    case (act)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    wave_nx = wave_q;
    if (force_i) begin
      wave_nx = pin_apply(wave_q, force_act_i);
    end else begin
      case (mode_i)
        MODE_FAST: begin
          if (pin_mode_i[1]) begin
            if (match_i)       wave_nx = pin_mode_i[0];
            else if (bottom_i) wave_nx = ~pin_mode_i[0];
          end
        end
        MODE_PHASE: begin
          if (pin_mode_i[1] && match_i) wave_nx = down_i ^ pin_mode_i[0];
        end
        default: begin
          if (match_i) wave_nx = pin_apply(wave_q, pin_mode_i);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) wave_q <= 1'b0;
    else       wave_q <= wave_nx;
  end

  assign wave_o = wave_q;

endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              tick_i,
  output logic              wave_o,
  output logic              wave_oe_o,
  output logic              cmp_flag_o,
  output logic              ovf_flag_o,
  output logic              irq_o
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_wr, force_stb, match, bottom, down, run;
  logic [1:0]       force_act;

  assign run = tick_i && (ctrl_q.clk_sel != 3'b000);

  tmr8_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wr_data_i   (wr_data_i),
    .cnt_i       (cnt_q),
    .match_i     (match),
    .bottom_i    (bottom),
    .ctrl_o      (ctrl_q),
    .cmp_o       (cmp_q),
    .rd_data_o   (rd_data_o),
    .cmp_flag_o  (cmp_flag_o),
    .ovf_flag_o  (ovf_flag_o),
    .irq_o       (irq_o),
    .cnt_wr_o    (cnt_wr),
    .force_o     (force_stb),
    .force_act_o (force_act)
  );

  tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .mode_i     (ctrl_q.mode),
    .run_i      (run),
    .load_i     (cnt_wr),
    .load_val_i (wr_data_i),
    .cmp_i      (cmp_q),
    .cnt_o      (cnt_q),
    .down_o     (down),
    .match_o    (match),
    .bottom_o   (bottom)
  );

  tmr8_wave u_wave (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mode_i      (ctrl_q.mode),
    .pin_mode_i  (ctrl_q.pin_mode),
    .match_i     (match),
    .bottom_i    (bottom),
    .down_i      (down),
    .force_i     (force_stb),
    .force_act_i (force_act),
    .wave_o      (wave_o)
  );

  assign wave_oe_o = |ctrl_q.pin_mode;

endmodule

// File: rtl/tmr8_wavegen_chk.sv
module tmr8_wavegen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             tick_i,
  input logic [1:0]       mode,
  input logic [2:0]       clk_sel,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             cmp_flag_o,
  input logic             ovf_flag_o,
  input logic             irq_o
);

  logic cnt_write;
  assign cnt_write = wr_en_i && (addr_i == 2'd1);

  p_strobe_reads_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && addr_i == 2'd0) |=> !rd_data_o[7]);

  p_stopped_holds_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (clk_sel == 3'b000 && !cnt_write) |=> $stable(cnt));

  p_top_returns_zero_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == 2'b10 && clk_sel != 3'b000 && tick_i && cnt == cmp && !cnt_write)
      |=> (cnt == '0 && cmp_flag_o));

  p_force_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == 2'd0 && wr_data_i[7] && !tick_i)
      |=> ($stable(cmp_flag_o) && $stable(ovf_flag_o) && $stable(cnt)));

  p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmp_flag_o && !(wr_en_i && addr_i == 2'd3 && wr_data_i[0])) |=> cmp_flag_o);

  p_irq_tracks_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == (cmp_flag_o || ovf_flag_o));

endmodule

bind tmr8_wavegen tmr8_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .tick_i     (tick_i),
  .mode       (ctrl_q.mode),
  .clk_sel    (ctrl_q.clk_sel),
  .cnt        (cnt_q),
  .cmp        (cmp_q),
  .cmp_flag_o (cmp_flag_o),
  .ovf_flag_o (ovf_flag_o),
  .irq_o      (irq_o)
);

// File: tb/tb_tmr8_wavegen.sv
module tb_tmr8_wavegen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic       wave, wave_oe, cflag, oflag, irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr8_wavegen #(.CNT_W(8)) dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wr_data_i  (wdata),
    .rd_data_o  (rdata),
    .tick_i     (tick),
    .wave_o     (wave),
    .wave_oe_o  (wave_oe),
    .cmp_flag_o (cflag),
    .ovf_flag_o (oflag),
    .irq_o      (irq)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  cmp;
    logic        init;
    logic [15:0] ticks;
    logic [7:0]  cnt;
    logic        flag;
    logic        ovf;
    logic        wave;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{8'h11, 8'd5,   1'b0, 16'd10,  8'd10,  1'b1, 1'b0, 1'b1},
    '{8'h19, 8'd3,   1'b0, 16'd7,   8'd3,   1'b1, 1'b0, 1'b1},
    '{8'h29, 8'd4,   1'b1, 16'd4,   8'd4,   1'b0, 1'b0, 1'b1},
    '{8'h29, 8'd4,   1'b1, 16'd5,   8'd0,   1'b1, 1'b0, 1'b0},
    '{8'h39, 8'd0,   1'b0, 16'd3,   8'd0,   1'b1, 1'b0, 1'b1},
    '{8'h01, 8'd2,   1'b1, 16'd5,   8'd5,   1'b1, 1'b0, 1'b1},
    '{8'h69, 8'd100, 1'b1, 16'd150, 8'd150, 1'b1, 1'b0, 1'b0},
    '{8'h69, 8'd100, 1'b0, 16'd256, 8'd0,   1'b1, 1'b1, 1'b1},
    '{8'h79, 8'd100, 1'b0, 16'd150, 8'd150, 1'b1, 1'b0, 1'b1},
    '{8'h61, 8'd200, 1'b1, 16'd300, 8'd210, 1'b1, 1'b0, 1'b0},
    '{8'h61, 8'd200, 1'b1, 16'd320, 8'd190, 1'b1, 1'b0, 1'b1},
    '{8'h61, 8'd200, 1'b1, 16'd511, 8'd1,   1'b1, 1'b1, 1'b1},
    '{8'h01, 8'd7,   1'b0, 16'd256, 8'd0,   1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic string tag_for(input logic [7:0] c);
    case ({c[3], c[6]})
      2'b00:   return "R4/R6";
      2'b10:   return "R5/R6";
      2'b11:   return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    chk("R1 wave after reset", wave, 0);
    chk("R1 oe after reset", wave_oe, 0);
    chk("R1 flags/irq after reset", {cflag, oflag, irq}, 0);

    // vector table: modes R4 R5 R6 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VEC[i];
      wr(2'd0, v.init ? 8'hB0 : 8'hA0);
      wr(2'd1, 8'd0);
      wr(2'd3, 8'h03);
      wr(2'd2, v.cmp);
      wr(2'd0, v.ctrl);
      pulse(int'(v.ticks));
      rd(2'd1, d);
      chk($sformatf("%s row %0d count", tag_for(v.ctrl), i), d, v.cnt);
      chk($sformatf("%s row %0d cmp flag", tag_for(v.ctrl), i), cflag, v.flag);
      chk($sformatf("%s row %0d ovf flag", tag_for(v.ctrl), i), oflag, v.ovf);
      chk($sformatf("%s row %0d wave", tag_for(v.ctrl), i), wave, v.wave);
    end

    // R8: force ignored in PWM modes
    wr(2'd0, 8'hB0);
    chk("R7 force set in normal", wave, 1);
    wr(2'd0, 8'hE8);
    chk("R8 force ignored fast PWM", wave, 1);
    wr(2'd0, 8'hE0);
    chk("R8 force ignored phase PWM", wave, 1);
    rd(2'd0, d);
    chk("R2 ctrl readback drops bit 7", d, 8'h60);

    // R7: force in CTC with count at compare, stopped
    wr(2'd2, 8'd9);
    wr(2'd1, 8'd9);
    wr(2'd0, 8'h08);
    wr(2'd3, 8'h03);
    wr(2'd0, 8'h98);
    chk("R7 force toggles wave", wave, 0);
    chk("R7 force no flag/irq", {cflag, oflag, irq}, 0);
    rd(2'd1, d);
    chk("R7 force keeps count", d, 9);
    wr(2'd0, 8'h98);
    chk("R7 second force toggles back", wave, 1);
    rd(2'd0, d);
    chk("R2 ctrl readback", d, 8'h18);

    // R3: stopped and enable-only advance
    wr(2'd0, 8'h08);
    pulse(5);
    rd(2'd1, d);
    chk("R3 clock select 000 holds count", d, 9);
    wr(2'd0, 8'h04);
    repeat (4) @(negedge clk);
    rd(2'd1, d);
    chk("R3 no tick no advance", d, 9);
    pulse(1);
    rd(2'd1, d);
    chk("R3 one tick one step", d, 10);

    // R6: pin enable follows field
    wr(2'd0, 8'h00);
    chk("R6 oe off for action 00", wave_oe, 0);
    wr(2'd0, 8'h20);
    chk("R6 oe on for action 10", wave_oe, 1);

    // R11: set wins over clear in same cycle
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h09);
    wr(2'd3, 8'h03);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 2'd3; wdata = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R11 set wins over clear", cflag, 1);
    chk("R11 irq with flag", irq, 1);
    rd(2'd1, d);
    chk("R5 CTC top to zero", d, 0);
    wr(2'd3, 8'h02);
    chk("R11 clearing other bit keeps flag", cflag, 1);
    wr(2'd3, 8'h01);
    chk("R11 write-one clears", {cflag, irq}, 0);
    rd(2'd3, d);
    chk("R2 flag register reads clear", d, 0);

    // R12: count write overrides enable and suppresses match
    wr(2'd2, 8'd0);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h09);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'd50;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R12 enable at write no match", cflag, 0);
    rd(2'd1, d);
    chk("R12 written count wins", d, 50);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule